// File: doc/BRIEF.md
# Serial Flash Command Front End with Address-Length Selection

This block sits on the device side of a single-bit serial flash link that runs in SPI mode 0. A system clock oversamples chip select, serial clock and the serial data input. After chip select falls, the block shifts in the first byte MSB first and classifies it. If the command carries an address, the block works out whether three or four address bytes follow and assembles them MSB first. When the command is complete, the block presents the opcode, a class code and the address, together with a one-cycle strobe.

The block keeps a small amount of volatile state that later commands depend on:
- the four-byte address mode, turned on and off by dedicated commands;
- the write-enable latch;
- a two-step software reset, made of an arm command followed by an execute command;
- a continuous-read mode. A mode byte after a fast read turns it on. In this mode, each following transaction starts directly with the address. An all-ones first byte leaves the mode.

Downstream logic uses the strobe and class to start array reads, programs or erases. It takes the address width from the strobe, so it never needs to track the mode itself.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, the four-byte mode flag, the write-enable latch and the continuous-read flag are all 0, and no strobe is produced.
- R2: While four-byte mode is off, opcodes 03h, 0Bh, 02h, 32h, 20h, 52h and D8h take three address bytes. The strobe comes after the third byte and carries the address zero-extended to 32 bits.
- R3: Opcode B7h (class 8) turns four-byte mode on and E9h (class 9) turns it off. While the mode is on, the opcodes of R2 take four address bytes.
- R4: Opcodes 13h, 0Ch, 12h, 34h, 21h, 53h and DCh always take four address bytes, whatever the mode flag holds.
- R5: The following commands strobe as soon as the opcode byte is complete, with address 0. The class codes are: read 1, program 2, erase 3, chip erase 60h/C7h 4, 06h 5, 04h 6, status read 05h 7, reset-arm 66h 10, reset-execute 99h 11, suspend 75h 12, resume 7Ah 13, mode reset FFh 14.
- R6: Opcode 06h sets the write-enable latch and 04h clears it. A program, erase or chip-erase command issued while the latch is clear strobes with the reject flag set. A command of those classes that is accepted clears the latch when its chip select rises, even if that rise lands in the same cycle as the final clock edge.
- R7: A 99h transaction that directly follows a completed 66h transaction clears the four-byte, write-enable and continuous-read flags. Any other strobed opcode in between, or a partial transaction in between, cancels the armed reset.
- R8: A transaction that ends before its opcode byte or its last address byte is complete produces no strobe and changes no flag.
- R9: An opcode that is not listed strobes with class 15. Every later bit is ignored until chip select rises.
- R10: The byte that follows the address of 0Bh or 0Ch is a mode byte. Upper nibble Ah sets the continuous-read flag; any other value clears it. While the flag is set, a transaction treats its first byte as the first address byte and repeats the last fast-read opcode.
- R11: While continuous-read mode is on, a first byte of FFh strobes class 14 with address 0 and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low, data sampled on rising edge |
| spi_mosi | input | 1 | Serial data into the device |
| cmd_valid | output | 1 | One-cycle strobe: command decoded and, if needed, address complete |
| cmd_opcode | output | 8 | Opcode of the strobed command |
| cmd_class | output | 4 | Class code of the strobed command |
| cmd_addr | output | 32 | Assembled address, zero-extended for three-byte addresses |
| cmd_reject | output | 1 | Program or erase strobed while the write-enable latch was clear |
| addr4_mode | output | 1 | Four-byte address mode flag |
| wel | output | 1 | Write-enable latch |
| cont_read | output | 1 | Continuous-read mode flag |

## Verification
Two events can fall on the same system-clock cycle: the final data bit that completes an accepted program or chip erase, and the rising edge of chip select that ends the transaction. The bench provokes this by raising chip select at the same instant as the last serial clock rising edge, so both are synchronised in the same cycle. The result is judged correct if the strobe for the chip erase is still reported in full, the transaction is not counted as partial, and the write-enable latch reads 0 afterwards.

// File: rtl/fcf_pkg.sv
// Shared types and the opcode table for the serial flash command front end.
// Assumes single-bit transfers, MSB first, eight-bit opcodes.
package fcf_pkg;

    localparam int OP_W      = 8;
    localparam int ADDR_BYTES = 4;
    localparam int ADDR_W    = 8 * ADDR_BYTES;

    typedef enum logic [3:0] {
        CL_NONE      = 4'd0,
        CL_READ      = 4'd1,
        CL_PROGRAM   = 4'd2,
        CL_ERASE     = 4'd3,
        CL_CHIP      = 4'd4,
        CL_WREN      = 4'd5,
        CL_WRDI      = 4'd6,
        CL_STATUS    = 4'd7,
        CL_ADDR4_ON  = 4'd8,
        CL_ADDR4_OFF = 4'd9,
        CL_RST_EN    = 4'd10,
        CL_RST_GO    = 4'd11,
        CL_SUSPEND   = 4'd12,
        CL_RESUME    = 4'd13,
        CL_MODE_RST  = 4'd14,
        CL_INVALID   = 4'd15
    } cls_e;

    typedef struct packed {
        cls_e cls;
        logic needs_addr;
        logic fixed4;
        logic has_mode;
    } dec_t;

    // Classes that modify the array and so depend on the write-enable latch.
    function automatic logic is_write_class(input cls_e c);
        return (c == CL_PROGRAM) || (c == CL_ERASE) || (c == CL_CHIP);
    endfunction

    // Map an opcode to its class and address properties.
    function automatic dec_t decode_op(input logic [OP_W-1:0] op);
        dec_t d;
        d = '{cls: CL_INVALID, needs_addr: 1'b0, fixed4: 1'b0, has_mode: 1'b0};
        case (op)
            8'h03: begin d.cls = CL_READ;    d.needs_addr = 1'b1; end
            8'h0B: begin d.cls = CL_READ;    d.needs_addr = 1'b1; d.has_mode = 1'b1; end
            8'h13: begin d.cls = CL_READ;    d.needs_addr = 1'b1; d.fixed4 = 1'b1; end
            8'h0C: begin d.cls = CL_READ;    d.needs_addr = 1'b1; d.fixed4 = 1'b1; d.has_mode = 1'b1; end
            8'h02, 8'h32: begin d.cls = CL_PROGRAM; d.needs_addr = 1'b1; end
            8'h12, 8'h34: begin d.cls = CL_PROGRAM; d.needs_addr = 1'b1; d.fixed4 = 1'b1; end
            8'h20, 8'h52, 8'hD8: begin d.cls = CL_ERASE; d.needs_addr = 1'b1; end
            8'h21, 8'h53, 8'hDC: begin d.cls = CL_ERASE; d.needs_addr = 1'b1; d.fixed4 = 1'b1; end
            8'h60, 8'hC7: d.cls = CL_CHIP;
            8'h06: d.cls = CL_WREN;
            8'h04: d.cls = CL_WRDI;
            8'h05: d.cls = CL_STATUS;
            8'hB7: d.cls = CL_ADDR4_ON;
            8'hE9: d.cls = CL_ADDR4_OFF;
            8'h66: d.cls = CL_RST_EN;
            8'h99: d.cls = CL_RST_GO;
            8'h75: d.cls = CL_SUSPEND;
            8'h7A: d.cls = CL_RESUME;
            8'hFF: d.cls = CL_MODE_RST;
            default: d.cls = CL_INVALID;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fcf_spi_sync.sv
// Brings chip select, serial clock and data into the system clock domain
// through equal-length flop chains, so their relative timing is kept.
// It then detects the serial clock rising edge and the end of the transaction.
// Assumes the system clock is several times faster than the serial clock.
module fcf_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sck_in,
    input  logic data_in,
    output logic cs_n_q,
    output logic data_q,
    output logic sck_rise,
    output logic cs_end
);
    localparam logic [2:0] IDLE_VAL = 3'b100;   // {cs_n, sck, data}

    logic [2:0] stg [STAGES];
    logic       sck_prev;
    logic       cs_prev;

    // First synchroniser stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= IDLE_VAL;
        else        stg[0] <= {cs_n_in, sck_in, data_in};
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Further stages of the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= IDLE_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    // Previous-cycle copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= stg[STAGES-1][1];
            cs_prev  <= stg[STAGES-1][2];
        end
    end

    assign cs_n_q   = stg[STAGES-1][2];
    assign data_q   = stg[STAGES-1][0];
    assign sck_rise = stg[STAGES-1][1] & ~sck_prev;
    assign cs_end   = stg[STAGES-1][2] & ~cs_prev;

endmodule

// File: rtl/fcf_op_classifier.sv
// Purely combinational opcode classifier wrapped around the package table.
module fcf_op_classifier
    import fcf_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output dec_t            info
);
    // Table lookup.
    always_comb info = decode_op(opcode);
endmodule

// File: rtl/fcf_cmd_fsm.sv
// Transaction sequencer: shifts serial bits, decodes the opcode, collects
// three or four address bytes and an optional mode byte, and issues one
// registered strobe per command. Reports the end of each transaction and
// whether it was partial. Assumes at most one serial rising edge per cycle.
module fcf_cmd_fsm
    import fcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_q,
    input  logic              data_q,
    input  logic              sck_rise,
    input  logic              cs_end,
    input  logic              addr4_mode,
    input  logic              wel,
    input  logic              cont_mode,
    output logic              v_out,
    output logic [OP_W-1:0]   op_out,
    output cls_e              cls_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic              rej_out,
    output logic              end_out,
    output logic              abort_out,
    output logic              mode_done,
    output logic [3:0]        mode_hi
);
    typedef enum logic [1:0] {ST_OPC, ST_ADR, ST_MOD, ST_SKIP} st_e;

    st_e               state;
    logic [2:0]        bit_cnt;
    logic [2:0]        byte_cnt;
    logic [ADDR_W-1:0] shreg;
    logic [OP_W-1:0]   cur_op;
    cls_e              cur_cls;
    logic              need4;
    logic              want_mode;
    logic [OP_W-1:0]   cont_op;
    logic              cont_f4;

    logic [ADDR_W-1:0] sh_next;
    logic              bit_take;
    logic              byte_done;
    dec_t              dec;
    logic              fire;
    logic [OP_W-1:0]   f_op;
    cls_e              f_cls;
    logic [ADDR_W-1:0] f_addr;

    fcf_op_classifier u_cls (.opcode(sh_next[OP_W-1:0]), .info(dec));

    assign sh_next   = {shreg[ADDR_W-2:0], data_q};
    // A bit landing in the same cycle as chip select rising still counts.
    assign bit_take  = sck_rise && (!cs_n_q || cs_end);
    assign byte_done = bit_take && (bit_cnt == 3'd7);

    // Decide whether this cycle completes a command and what it reports.
    always_comb begin
        fire   = 1'b0;
        f_op   = sh_next[OP_W-1:0];
        f_cls  = dec.cls;
        f_addr = '0;
        if (byte_done) begin
            case (state)
                ST_OPC: begin
                    if (cont_mode) begin
                        if (sh_next[OP_W-1:0] == 8'hFF) begin
                            fire  = 1'b1;
                            f_cls = CL_MODE_RST;
                        end
                    end else if (!dec.needs_addr) begin
                        fire = 1'b1;
                    end
                end
                ST_ADR: begin
                    if (byte_cnt == (need4 ? 3'd3 : 3'd2)) begin
                        fire   = 1'b1;
                        f_op   = cur_op;
                        f_cls  = cur_cls;
                        f_addr = need4 ? sh_next : {8'h00, sh_next[23:0]};
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequencer state, shift register and registered command outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OPC;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            shreg     <= '0;
            cur_op    <= '0;
            cur_cls   <= CL_NONE;
            need4     <= 1'b0;
            want_mode <= 1'b0;
            cont_op   <= 8'h0B;
            cont_f4   <= 1'b0;
            v_out     <= 1'b0;
            op_out    <= '0;
            cls_out   <= CL_NONE;
            addr_out  <= '0;
            rej_out   <= 1'b0;
            end_out   <= 1'b0;
            abort_out <= 1'b0;
            mode_done <= 1'b0;
            mode_hi   <= '0;
        end else begin
            v_out     <= fire;
            end_out   <= 1'b0;
            abort_out <= 1'b0;
            mode_done <= 1'b0;
            if (fire) begin
                op_out   <= f_op;
                cls_out  <= f_cls;
                addr_out <= f_addr;
                rej_out  <= is_write_class(f_cls) && !wel;
            end
            if (bit_take) begin
                shreg   <= sh_next;
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
                case (state)
                    ST_OPC: begin
                        if (cont_mode) begin
                            if (fire) state <= ST_SKIP;
                            else begin
                                cur_op    <= cont_op;
                                cur_cls   <= CL_READ;
                                need4     <= cont_f4 | addr4_mode;
                                want_mode <= 1'b1;
                                byte_cnt  <= 3'd1;
                                state     <= ST_ADR;
                            end
                        end else if (fire) begin
                            state <= ST_SKIP;
                        end else begin
                            cur_op    <= sh_next[OP_W-1:0];
                            cur_cls   <= dec.cls;
                            need4     <= dec.fixed4 | addr4_mode;
                            want_mode <= dec.has_mode;
                            byte_cnt  <= '0;
                            state     <= ST_ADR;
                            if (dec.has_mode) begin
                                cont_op <= sh_next[OP_W-1:0];
                                cont_f4 <= dec.fixed4;
                            end
                        end
                    end
                    ST_ADR: begin
                        byte_cnt <= byte_cnt + 3'd1;
                        if (fire) state <= want_mode ? ST_MOD : ST_SKIP;
                    end
                    ST_MOD: begin
                        mode_done <= 1'b1;
                        mode_hi   <= sh_next[7:4];
                        state     <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
            if (cs_end) begin
                end_out   <= 1'b1;
                abort_out <= ((state == ST_OPC) || (state == ST_ADR)) && !fire;
                state     <= ST_OPC;
                bit_cnt   <= '0;
                byte_cnt  <= '0;
            end
        end
    end

    // R8
    partial_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADR && cs_end && !sck_rise) |=> !v_out);

    // R9
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> !v_out);

    // R2
    short_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_out && !addr4_mode && op_out == 8'h03) |-> (addr_out[31:24] == 8'h00));

    // R5
    noaddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_out && (cls_out == CL_WREN || cls_out == CL_SUSPEND || cls_out == CL_CHIP))
        |-> (addr_out == '0));

endmodule

// File: rtl/fcf_mode_state.sv
// Volatile command state: four-byte address mode, write-enable latch,
// continuous-read flag and the armed software reset. Updates on strobes,
// transaction ends and mode bytes from the sequencer.
module fcf_mode_state
    import fcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       v,
    input  cls_e       cls,
    input  logic       rej,
    input  logic       end_evt,
    input  logic       abort,
    input  logic       mode_done,
    input  logic [3:0] mode_hi,
    output logic       addr4,
    output logic       wel,
    output logic       cont
);
    logic armed;
    logic clr_pend;

    // Apply command effects; an end in the same cycle as a strobe sees both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr4    <= 1'b0;
            wel      <= 1'b0;
            cont     <= 1'b0;
            armed    <= 1'b0;
            clr_pend <= 1'b0;
        end else begin
            if (v) begin
                armed <= (cls == CL_RST_EN);
                case (cls)
                    CL_WREN:      wel   <= 1'b1;
                    CL_WRDI:      wel   <= 1'b0;
                    CL_ADDR4_ON:  addr4 <= 1'b1;
                    CL_ADDR4_OFF: addr4 <= 1'b0;
                    CL_MODE_RST:  cont  <= 1'b0;
                    CL_RST_GO: begin
                        if (armed) begin
                            addr4    <= 1'b0;
                            wel      <= 1'b0;
                            cont     <= 1'b0;
                            clr_pend <= 1'b0;
                        end
                    end
                    default: ;
                endcase
                if (is_write_class(cls) && !rej) clr_pend <= 1'b1;
            end
            if (abort) armed <= 1'b0;
            if (end_evt && (clr_pend || (v && is_write_class(cls) && !rej))) begin
                wel      <= 1'b0;
                clr_pend <= 1'b0;
            end
            if (mode_done) cont <= (mode_hi == 4'hA);
        end
    end

    // R6
    wel_end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && clr_pend) |=> !wel);

    // R7
    reset_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v && cls == CL_RST_GO && armed) |=> (!addr4 && !wel && !cont));

    // R10
    cont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_done && mode_hi == 4'hA) |=> cont);

    // R3
    addr4_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v && cls == CL_ADDR4_ON) |=> addr4);

endmodule

// File: rtl/flash_cmd_frontend.sv
// Top level: synchroniser, transaction sequencer and volatile mode state.
// Assumes SPI mode 0 with the system clock well above the serial clock.
module flash_cmd_frontend
    import fcf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_opcode,
    output logic [3:0]        cmd_class,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_reject,
    output logic              addr4_mode,
    output logic              wel,
    output logic              cont_read
);
    logic cs_n_q, data_q, sck_rise, cs_end;
    logic end_evt, abort, mode_done;
    logic [3:0] mode_hi;
    cls_e cls;

    fcf_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_in(spi_cs_n), .sck_in(spi_sck), .data_in(spi_mosi),
        .cs_n_q(cs_n_q), .data_q(data_q), .sck_rise(sck_rise), .cs_end(cs_end)
    );

    fcf_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_n_q(cs_n_q), .data_q(data_q), .sck_rise(sck_rise), .cs_end(cs_end),
        .addr4_mode(addr4_mode), .wel(wel), .cont_mode(cont_read),
        .v_out(cmd_valid), .op_out(cmd_opcode), .cls_out(cls), .addr_out(cmd_addr),
        .rej_out(cmd_reject), .end_out(end_evt), .abort_out(abort),
        .mode_done(mode_done), .mode_hi(mode_hi)
    );

    fcf_mode_state u_state (
        .clk(clk), .rst_n(rst_n),
        .v(cmd_valid), .cls(cls), .rej(cmd_reject),
        .end_evt(end_evt), .abort(abort),
        .mode_done(mode_done), .mode_hi(mode_hi),
        .addr4(addr4_mode), .wel(wel), .cont(cont_read)
    );

    assign cmd_class = cls;

endmodule

// File: tb/test_flash_cmd_frontend.sv
module test_flash_cmd_frontend;
    import fcf_pkg::*;

    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        cmd_valid, cmd_reject, addr4_mode, wel, cont_read;
    logic [7:0]  cmd_opcode;
    logic [3:0]  cmd_class;
    logic [31:0] cmd_addr;

    always #4 clk = ~clk;   // 125 MHz

    flash_cmd_frontend i_flash_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_class(cmd_class),
        .cmd_addr(cmd_addr), .cmd_reject(cmd_reject),
        .addr4_mode(addr4_mode), .wel(wel), .cont_read(cont_read)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [3:0]  cls;
        logic [31:0] addr;
        logic        rej;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    item_t got, want;
    string wtag;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Monitor: pop the expected item for every strobe and compare.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            checks++;
            got = '{op: cmd_opcode, cls: cmd_class, addr: cmd_addr, rej: cmd_reject};
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected strobe: actual op=%h cls=%0d addr=%h rej=%b, expected none",
                         cmd_opcode, cmd_class, cmd_addr, cmd_reject);
            end else begin
                want = exp_q.pop_front();
                wtag = tag_q.pop_front();
                if (got !== want) begin
                    errors++;
                    $display("FAIL %s: actual op=%h cls=%0d addr=%h rej=%b, expected op=%h cls=%0d addr=%h rej=%b",
                             wtag, got.op, got.cls, got.addr, got.rej,
                             want.op, want.cls, want.addr, want.rej);
                end
            end
        end
    end

    task automatic expect_cmd(input string tag, input logic [7:0] op, input logic [3:0] cls,
                              input logic [31:0] addr, input logic rej);
        exp_q.push_back('{op: op, cls: cls, addr: addr, rej: rej});
        tag_q.push_back(tag);
    endtask

    // Drive nbits of left-aligned data; cut raises chip select with the last rising edge.
    task automatic xfer(input logic [63:0] data, input int nbits, input bit cut);
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = data[63-i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            if (cut && i == nbits - 1) cs_n = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int nbytes, input bit cut);
        xfer(v << (64 - 8 * nbytes), 8 * nbytes, cut);
    endtask

    // Every expected strobe must have been seen by now.
    task automatic drained(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: actual %0d strobes missing, expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic chk_flags(input string tag, input logic a4, input logic w, input logic c);
        checks++;
        if ({addr4_mode, wel, cont_read} !== {a4, w, c}) begin
            errors++;
            $display("FAIL %s: actual a4/wel/cont=%b%b%b, expected %b%b%b",
                     tag, addr4_mode, wel, cont_read, a4, w, c);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] v, input int nbytes);
        send(v, nbytes, 1'b0);
        drained(tag);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk_flags("R1 reset flags", 1'b0, 1'b0, 1'b0);

        // R2 three-byte address in default mode
        expect_cmd("R2 read 3B", 8'h03, CL_READ, 32'h0012_3456, 1'b0);
        run("R2 read 3B", 64'h03_123456, 4);
        chk_flags("R2 flags", 1'b0, 1'b0, 1'b0);

        // R5 single-byte commands
        expect_cmd("R5 status", 8'h05, CL_STATUS, 32'h0, 1'b0);
        run("R5 status", 64'h05, 1);
        expect_cmd("R5 suspend", 8'h75, CL_SUSPEND, 32'h0, 1'b0);
        run("R5 suspend", 64'h75, 1);
        expect_cmd("R5 resume", 8'h7A, CL_RESUME, 32'h0, 1'b0);
        run("R5 resume", 64'h7A, 1);

        // R6 reject when latch clear
        expect_cmd("R6 program rejected", 8'h02, CL_PROGRAM, 32'h00AA_BBCC, 1'b1);
        run("R6 program rejected", 64'h02_AABBCC, 4);
        chk_flags("R6 latch still clear", 1'b0, 1'b0, 1'b0);
        expect_cmd("R6 wren", 8'h06, CL_WREN, 32'h0, 1'b0);
        run("R6 wren", 64'h06, 1);
        chk_flags("R6 latch set", 1'b0, 1'b1, 1'b0);
        expect_cmd("R6 erase accepted", 8'h20, CL_ERASE, 32'h0001_0203, 1'b0);
        run("R6 erase accepted", 64'h20_010203, 4);
        chk_flags("R6 latch auto-clear", 1'b0, 1'b0, 1'b0);
        expect_cmd("R6 wren2", 8'h06, CL_WREN, 32'h0, 1'b0);
        run("R6 wren2", 64'h06, 1);
        expect_cmd("R6 wrdi", 8'h04, CL_WRDI, 32'h0, 1'b0);
        run("R6 wrdi", 64'h04, 1);
        chk_flags("R6 wrdi clears", 1'b0, 1'b0, 1'b0);

        // R3 four-byte mode
        expect_cmd("R3 enter", 8'hB7, CL_ADDR4_ON, 32'h0, 1'b0);
        run("R3 enter", 64'hB7, 1);
        chk_flags("R3 mode on", 1'b1, 1'b0, 1'b0);
        expect_cmd("R3 read 4B", 8'h03, CL_READ, 32'h1122_3344, 1'b0);
        run("R3 read 4B", 64'h03_11223344, 5);
        expect_cmd("R3 half-block 4B", 8'h52, CL_ERASE, 32'hF0E1_D2C3, 1'b1);
        run("R3 half-block 4B", 64'h52_F0E1D2C3, 5);
        expect_cmd("R3 exit", 8'hE9, CL_ADDR4_OFF, 32'h0, 1'b0);
        run("R3 exit", 64'hE9, 1);
        chk_flags("R3 mode off", 1'b0, 1'b0, 1'b0);

        // R4 fixed four-byte group in three-byte mode
        expect_cmd("R4 read13", 8'h13, CL_READ, 32'hDEAD_BEEF, 1'b0);
        run("R4 read13", 64'h13_DEADBEEF, 5);
        expect_cmd("R4 wren", 8'h06, CL_WREN, 32'h0, 1'b0);
        run("R4 wren", 64'h06, 1);
        expect_cmd("R4 block DC", 8'hDC, CL_ERASE, 32'h0102_0304, 1'b0);
        run("R4 block DC", 64'hDC_01020304, 5);
        chk_flags("R4 latch auto-clear", 1'b0, 1'b0, 1'b0);

        // R8 partial transactions
        expect_cmd("R8 wren", 8'h06, CL_WREN, 32'h0, 1'b0);
        run("R8 wren", 64'h06, 1);
        xfer({8'h02, 8'h11, 8'h22, 40'h0}, 24, 1'b0);
        drained("R8 partial address");
        chk_flags("R8 latch kept", 1'b0, 1'b1, 1'b0);
        xfer({8'hB7, 56'h0}, 5, 1'b0);
        drained("R8 partial opcode");
        chk_flags("R8 mode kept", 1'b0, 1'b1, 1'b0);

        // R6 chip select rises in the cycle of the last bit
        expect_cmd("R6 chip erase cut", 8'hC7, CL_CHIP, 32'h0, 1'b0);
        send(64'hC7, 1, 1'b1);
        drained("R6 chip erase cut");
        chk_flags("R6 latch cleared after cut", 1'b0, 1'b0, 1'b0);
        expect_cmd("R5 chip 60 rejected", 8'h60, CL_CHIP, 32'h0, 1'b1);
        run("R5 chip 60 rejected", 64'h60, 1);

        // R7 software reset
        expect_cmd("R7 enter", 8'hB7, CL_ADDR4_ON, 32'h0, 1'b0);
        run("R7 enter", 64'hB7, 1);
        expect_cmd("R7 wren", 8'h06, CL_WREN, 32'h0, 1'b0);
        run("R7 wren", 64'h06, 1);
        expect_cmd("R7 arm", 8'h66, CL_RST_EN, 32'h0, 1'b0);
        run("R7 arm", 64'h66, 1);
        expect_cmd("R7 go", 8'h99, CL_RST_GO, 32'h0, 1'b0);
        run("R7 go", 64'h99, 1);
        chk_flags("R7 reset applied", 1'b0, 1'b0, 1'b0);
        expect_cmd("R7 enter2", 8'hB7, CL_ADDR4_ON, 32'h0, 1'b0);
        run("R7 enter2", 64'hB7, 1);
        expect_cmd("R7 arm2", 8'h66, CL_RST_EN, 32'h0, 1'b0);
        run("R7 arm2", 64'h66, 1);
        expect_cmd("R7 between", 8'h05, CL_STATUS, 32'h0, 1'b0);
        run("R7 between", 64'h05, 1);
        expect_cmd("R7 go cancelled", 8'h99, CL_RST_GO, 32'h0, 1'b0);
        run("R7 go cancelled", 64'h99, 1);
        chk_flags("R7 cancelled by opcode", 1'b1, 1'b0, 1'b0);
        expect_cmd("R7 arm3", 8'h66, CL_RST_EN, 32'h0, 1'b0);
        run("R7 arm3", 64'h66, 1);
        xfer({8'hA0, 56'h0}, 3, 1'b0);
        expect_cmd("R7 go after partial", 8'h99, CL_RST_GO, 32'h0, 1'b0);
        run("R7 go after partial", 64'h99, 1);
        chk_flags("R7 cancelled by partial", 1'b1, 1'b0, 1'b0);
        expect_cmd("R7 exit", 8'hE9, CL_ADDR4_OFF, 32'h0, 1'b0);
        run("R7 exit", 64'hE9, 1);

        // R9 invalid opcode, trailing write enable ignored
        expect_cmd("R9 invalid", 8'h5A, CL_INVALID, 32'h0, 1'b0);
        run("R9 invalid", 64'h5A_06_03, 3);
        chk_flags("R9 trailing ignored", 1'b0, 1'b0, 1'b0);

        // R10 continuous read
        expect_cmd("R10 fast read", 8'h0B, CL_READ, 32'h0000_1234, 1'b0);
        run("R10 fast read", 64'h0B_001234_A5, 5);
        chk_flags("R10 cont set", 1'b0, 1'b0, 1'b1);
        expect_cmd("R10 cont access", 8'h0B, CL_READ, 32'h0000_4080, 1'b0);
        run("R10 cont access", 64'h004080_A0, 4);
        chk_flags("R10 cont kept", 1'b0, 1'b0, 1'b1);

        // R11 mode reset byte leaves continuous mode
        expect_cmd("R11 mode reset", 8'hFF, CL_MODE_RST, 32'h0, 1'b0);
        run("R11 mode reset", 64'hFF, 1);
        chk_flags("R11 cont cleared", 1'b0, 1'b0, 1'b0);
        expect_cmd("R10 fast read 2", 8'h0B, CL_READ, 32'h00AB_CDEF, 1'b0);
        run("R10 fast read 2", 64'h0B_ABCDEF_A0, 5);
        expect_cmd("R10 cont exit by mode", 8'h0B, CL_READ, 32'h0000_0001, 1'b0);
        run("R10 cont exit by mode", 64'h000001_55, 4);
        chk_flags("R10 cont cleared by mode byte", 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule